// File: doc/BRIEF.md
# Wake Pin Debounce Filter Bank

This block filters a bank of raw wake-up pins before they reach a power controller that runs on a 32768 Hz slow clock. Each pin has its own enable bit and polarity bit. Every raw pin first passes through a two-flop synchronizer. It then reaches a filter that tracks how long the pin has stayed at its active level. The filter issues a wake request once that level has held for the required number of slow-clock cycles.

One 3-bit period code, shared by every pin, selects how long the level must hold. There are six non-uniform hold lengths. The shortest is zero cycles, which passes the input through at once. The longest is 32768 cycles, about one second. A fired pin shows up as a one-cycle pulse on its bit of a wake vector, together with a combined wake request. The pin re-arms only after it has left its active level.

Top module: `wake_debounce_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge. Reset also clears all hold counters and the synchronizer stages.
- R2: A pin's active level is high when its `pin_pol` bit is 1 and low when it is 0. A pin sitting at its inactive level never fires.
- R3: A pin whose `pin_en` bit is 0 never raises its `wake_vec` bit, whatever its raw input does.
- R4: Code 0 is pass-through. The pin fires on the first synchronized sample that shows the active level.
- R5: Codes 1, 2, 3, 4 and 5 set the hold length N to 3, 32, 512, 4096 and 32768 cycles. A pin fires after N+1 consecutive synchronized active samples.
- R6: Codes 6 and 7 select the same hold length as code 5, which is 32768 cycles.
- R7: If a pin leaves its active level for even one synchronized sample before it fires, its count starts again from zero.
- R8: Each active episode gives exactly one single-cycle pulse, however long the level is held. A new pulse needs the pin to leave its active level and return.
- R9: `wake_req` is high in exactly the cycles in which `wake_vec` is nonzero.
- R10: A raw pin reaches the filters through two synchronizer flops. Its output bit can change no earlier than the third clock edge after the raw input changes.
- R11: The pins work independently. Bit i of `wake_vec` belongs to pin i, and several pins can fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NUM_PINS | Asynchronous raw wake pins |
| pin_en | input | NUM_PINS | Per-pin enable; 1 lets the pin fire |
| pin_pol | input | NUM_PINS | Per-pin active level; 1 = high, 0 = low |
| period_code | input | 3 | Shared hold-length selector (0..7) |
| wake_vec | output | NUM_PINS | One-cycle pulse on bit i when pin i fires |
| wake_req | output | 1 | High whenever any bit of wake_vec is high |

## Verification
Suppose a raw pin change is driven between edges and the period code selects a hold of N cycles. The matching `wake_vec` bit and `wake_req` are then due in the cycle after the (3+N)-th following clock edge. The bench's directed checks sample exactly one cycle before and at that moment. They sample on the falling edge, so no result depends on process order at the rising edge. A behavioural model sees the same inputs at each rising edge. It models the two-stage delay with a queue and the hold with integer run lengths. Its predicted vector is compared with both outputs on every falling edge. Drops, re-arms and disabled pins are therefore checked in every cycle, not just at the due point.

// File: rtl/wkdb_pkg.sv
package wkdb_pkg;

  localparam int unsigned WKDB_CODE_W   = 3;
  localparam int unsigned WKDB_HOLD_MAX = 32768;
  localparam int unsigned WKDB_HOLD_W   = $clog2(WKDB_HOLD_MAX + 1);

  typedef logic [WKDB_CODE_W-1:0] period_code_t;
  typedef logic [WKDB_HOLD_W-1:0] hold_t;

  // Hold length in slow-clock cycles for each code; codes above 5 saturate.
  function automatic hold_t wkdb_hold_of(input period_code_t code);
    hold_t h;
    case (code)
      3'd0:    h = hold_t'(0);
      3'd1:    h = hold_t'(3);
      3'd2:    h = hold_t'(32);
      3'd3:    h = hold_t'(512);
      3'd4:    h = hold_t'(4096);
      default: h = hold_t'(WKDB_HOLD_MAX);
    endcase
    return h;
  endfunction

endpackage

// File: rtl/wkdb_sync.sv
module wkdb_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/wkdb_period_decode.sv
module wkdb_period_decode
  import wkdb_pkg::*;
(
  input  period_code_t code,
  output hold_t        hold
);

  always_comb begin
    hold = wkdb_hold_of(code);
  end

endmodule

// File: rtl/wkdb_filter.sv
module wkdb_filter
  import wkdb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sync_in,
  input  logic  pol,
  input  logic  en,
  input  hold_t hold,
  output logic  fire_now
);

  logic  active;
  logic  fired;
  logic  reached;
  hold_t run_cnt;

  assign active   = en & (sync_in == pol);
  assign reached  = (run_cnt >= hold);
  assign fire_now = active & ~fired & reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      fired   <= 1'b0;
    end else if (!active) begin
      run_cnt <= '0;
      fired   <= 1'b0;
    end else if (!fired) begin
      if (reached) begin
        fired <= 1'b1;
      end else begin
        run_cnt <= run_cnt + hold_t'(1);
      end
    end
  end

endmodule

// File: rtl/wake_debounce_bank.sv
module wake_debounce_bank
  import wkdb_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_PINS-1:0]    pin_raw,
  input  logic [NUM_PINS-1:0]    pin_en,
  input  logic [NUM_PINS-1:0]    pin_pol,
  input  logic [WKDB_CODE_W-1:0] period_code,
  output logic [NUM_PINS-1:0]    wake_vec,
  output logic                   wake_req
);

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] fire_now;
  hold_t               hold_len;

  wkdb_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_sync)
  );

  wkdb_period_decode u_decode (
    .code (period_code),
    .hold (hold_len)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    wkdb_filter u_filter (
      .clk      (clk),
      .rst      (rst),
      .sync_in  (pin_sync[i]),
      .pol      (pin_pol[i]),
      .en       (pin_en[i]),
      .hold     (hold_len),
      .fire_now (fire_now[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_vec <= '0;
      wake_req <= 1'b0;
    end else begin
      wake_vec <= fire_now;
      wake_req <= |fire_now;
    end
  end

endmodule

// File: rtl/wkdb_checker.sv
module wkdb_checker #(
  parameter int unsigned NUM_PINS = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pin_raw,
  input logic [NUM_PINS-1:0] pin_en,
  input logic [NUM_PINS-1:0] pin_pol,
  input logic [NUM_PINS-1:0] wake_vec,
  input logic                wake_req
);

  // Saturating count of clock edges seen out of reset, so the deep $past only looks at post-reset history.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (wake_vec == '0 && !wake_req));

  a_r9_req_tracks_vec: assert property (@(posedge clk) disable iff (rst)
    wake_req == (|wake_vec));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    a_r3_disabled_silent: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 2'd0 && !$past(pin_en[i])) |-> !wake_vec[i]);

    a_r2_level_match: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && wake_vec[i]) |-> ($past(pin_raw[i], 3) == $past(pin_pol[i])));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      wake_vec[i] |=> !wake_vec[i]);
  end

endmodule

bind wake_debounce_bank wkdb_checker #(.NUM_PINS(NUM_PINS)) u_wkdb_chk (
  .clk      (clk),
  .rst      (rst),
  .pin_raw  (pin_raw),
  .pin_en   (pin_en),
  .pin_pol  (pin_pol),
  .wake_vec (wake_vec),
  .wake_req (wake_req)
);

// File: tb/wake_debounce_bank_test.sv
module wake_debounce_bank_test;

  localparam int unsigned NP    = 16;
  localparam int          LIMIT = 200000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_en  = '0;
  logic [NP-1:0] pin_pol = '1;
  logic [2:0]    period_code = 3'd0;
  logic [NP-1:0] wake_vec;
  logic          wake_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit live   = 0;
  string phase = "R1";

  wake_debounce_bank #(.NUM_PINS(NP)) uut (
    .clk (clk), .rst (rst), .pin_raw (pin_raw), .pin_en (pin_en),
    .pin_pol (pin_pol), .period_code (period_code),
    .wake_vec (wake_vec), .wake_req (wake_req)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  logic [NP-1:0] hist[$];
  int            run[NP];
  bit            spent[NP];
  logic [NP-1:0] exp_vec = '0;

  function automatic int hold_ref(input int code);
    int lens[6] = '{0, 3, 32, 512, 4096, 32768};
    return lens[(code > 5) ? 5 : code];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist = {};
      hist.push_back('0);
      hist.push_back('0);
      foreach (run[i]) begin run[i] = 0; spent[i] = 0; end
      exp_vec = '0;
    end else begin
      logic [NP-1:0] seen;
      seen = hist.pop_front();
      for (int i = 0; i < NP; i++) begin
        exp_vec[i] = 1'b0;
        if (!(pin_en[i] && seen[i] == pin_pol[i])) begin
          run[i] = 0; spent[i] = 0;
        end else if (!spent[i]) begin
          if (run[i] >= hold_ref(int'(period_code))) begin
            exp_vec[i] = 1'b1; spent[i] = 1;
          end else run[i]++;
        end
      end
      hist.push_back(pin_raw);
    end
    live = 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wake_vec actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model (R9 covers wake_req)
  always @(negedge clk) begin
    if (live && !done) begin
      check(phase, wake_vec, exp_vec);
      checks++;
      if (wake_req !== (|exp_vec)) begin
        fails++;
        $display("FAIL R9: wake_req actual %b expected %b at cycle %0d", wake_req, |exp_vec, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic long_hold(input int pin, input int code, input string req);
    phase = req;
    period_code = 3'(code);
    pin_en[pin] = 1'b1;
    step(3);
    pin_raw[pin] = 1'b1;
    step(2 + hold_ref(code));
    check(req, wake_vec, '0);
    step(1);
    check(req, wake_vec, NP'(1) << pin);
    step(1);
    pin_raw[pin] = 1'b0;
    pin_en[pin] = 1'b0;
    step(4);
  endtask

  initial begin
    @(negedge clk);
    step(2);
    check("R1", wake_vec, '0);                 // R1 reset state
    rst = 1'b0;
    step(2);

    phase = "R4";                              // R4 pass-through, R10 latency, R8 one pulse
    pin_en[0] = 1'b1;
    step(3);
    pin_raw[0] = 1'b1;
    step(2);
    check("R10", wake_vec, '0);
    step(1);
    check("R4", wake_vec, 16'h0001);
    step(1);
    check("R8", wake_vec, '0);
    step(10);
    check("R8", wake_vec, '0);
    pin_raw[0] = 1'b0;
    step(5);
    pin_raw[0] = 1'b1;
    step(3);
    check("R8", wake_vec, 16'h0001);           // re-armed after leaving active
    pin_raw[0] = 1'b0;
    pin_en[0] = 1'b0;
    step(4);

    long_hold(1, 1, "R5");                     // R5 code 1, N=3

    phase = "R7";                              // R7 restart on a one-cycle drop, code 2
    period_code = 3'd2;
    pin_en[2] = 1'b1;
    pin_raw[2] = 1'b1;
    step(20);
    pin_raw[2] = 1'b0;
    step(1);
    pin_raw[2] = 1'b1;
    step(34);
    check("R7", wake_vec, '0);
    step(1);
    check("R7", wake_vec, 16'h0004);
    pin_raw[2] = 1'b0;
    pin_en[2] = 1'b0;
    step(4);

    long_hold(8, 3, "R5");                     // R5 code 3, N=512
    long_hold(9, 4, "R5");                     // R5 code 4, N=4096

    phase = "R2";                              // R2 active-low pin, code 1
    period_code = 3'd1;
    pin_pol[3] = 1'b0;
    pin_raw[3] = 1'b1;
    pin_en[3] = 1'b1;
    step(8);
    check("R2", wake_vec, '0);                 // held high: inactive for this pin
    pin_raw[3] = 1'b0;
    step(5);
    check("R2", wake_vec, '0);
    step(1);
    check("R2", wake_vec, 16'h0008);
    pin_en[3] = 1'b0;
    step(4);

    phase = "R3";                              // R3 disabled pin toggling, code 0
    period_code = 3'd0;
    for (int k = 0; k < 4; k++) begin
      pin_raw[4] = ~pin_raw[4];
      step(4);
      check("R3", wake_vec, '0);
    end
    pin_raw[4] = 1'b0;
    step(4);

    phase = "R11";                             // R11 two pins fire together
    pin_en[7:6] = 2'b11;
    step(3);
    pin_raw[7:6] = 2'b11;
    step(3);
    check("R11", wake_vec, 16'h00C0);
    pin_raw[7:6] = 2'b00;
    pin_en[7:6] = 2'b00;
    step(4);

    long_hold(10, 5, "R5");                    // R5 code 5, N=32768
    long_hold(5, 7, "R6");                     // R6 code 7 acts as code 5
    long_hold(11, 6, "R6");                    // R6 code 6 acts as code 5

    done = 1;
    summary();
    $finish;
  end

endmodule